// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of up to seven DMA channels may use the shared transfer engine next. A channel counts as pending when its hardware request line or its software trigger is high and the channel is enabled. Each channel also carries a two-bit priority level that software sets. Arbitration has two stages. The highest level among the pending channels wins first. If several pending channels share that level, the one with the lowest index wins.

Only one channel holds the grant at a time. The arbiter keeps that grant until the granted channel pulses `item_done` to say that its data item has finished. There is no pre-emption in the middle of an item. The arbiter decides again only when no grant is held or when an item finishes. In either case the new grant appears on the clock edge that follows. Priority levels and enables may change at any time; a change is seen only at the next decision point. The channel datapaths and the sharing of the bus with the CPU lie outside this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `rst` is high, and after it is released until a request arrives, `grant` is all zeros, `grant_idx` is 0 and `grant_valid` is 0.
- R2: Channel c is pending when (`hw_req[c]` OR `sw_trig[c]`) AND `ch_en[c]`. A channel whose enable bit is 0 is never granted, even if its request or trigger is high. Either request source alone is enough for an enabled channel.
- R3: At a decision point, the grant goes to a pending channel whose level is the highest among the pending channels. Channel c's level is `pri_lvl[2c+1:2c]`, where 3 is the most urgent and 0 the least.
- R4: When several pending channels share the winning level, the channel with the lowest index is granted.
- R5: `grant` has at most one bit set. `grant_valid` is 1 exactly when `grant` is nonzero, and `grant_idx` is the position of that bit (0 when no grant is held).
- R6: While a grant is held and `item_done` is low, `grant` and `grant_idx` stay unchanged, even if a channel with a higher level becomes pending.
- R7: When `item_done` is high at a rising edge while a grant is held, that edge loads the winner among the channels pending in that cycle. If no channel is pending, it clears the grant and `grant_valid` goes low.
- R8: When no grant is held, the rising edge after a cycle in which some channel is pending loads that cycle's winner. The latency is one clock.
- R9: A change of priority levels while a grant is held does not alter that grant. The new levels decide the next winner at the next decision point.
- R10: `item_done` high while no grant is held has no effect other than the normal idle arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | NUM_CH | Hardware request line of each channel |
| sw_trig | input | NUM_CH | Software trigger of each channel |
| ch_en | input | NUM_CH | Channel enable; 0 removes the channel from arbitration |
| pri_lvl | input | NUM_CH*LVL_W | Level of channel c in bits [LVL_W*c +: LVL_W]; larger is more urgent |
| item_done | input | 1 | Pulse from the granted channel when its current item ends |
| grant | output | NUM_CH | One-hot grant, all zeros when idle |
| grant_idx | output | IDX_W | Index of the granted channel, 0 when idle |
| grant_valid | output | 1 | High while a grant is held |

## Verification
The bench targets five weak spots:
- **Tied levels.** An arbiter that resolved ties toward the highest index would grant channel 6 instead of channel 1.
- **Disabled requester.** A design that forgot the enable mask would hand the bus to a channel that is switched off.
- **Higher level mid-item.** When a more urgent channel appears during an item, a pre-empting design would move the grant before `item_done`. This corrupts the item in flight.
- **Late priority change.** A priority change made during an item must pick the next winner at the done edge, not earlier and not one decision late.
- **Done while idle.** A stray `item_done` with nothing pending must leave the outputs at zero.

Random traffic with mixed levels, enables and done pulses then tests the one-cycle turnaround against a reference chooser written from the priority rules alone.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int unsigned CH_COUNT_DEF = 7;
    localparam int unsigned LVL_BITS_DEF = 2;

    // Named levels for the default two-bit priority field
    typedef enum logic [1:0] {
        PRI_LOW  = 2'd0,
        PRI_MED  = 2'd1,
        PRI_HIGH = 2'd2,
        PRI_TOP  = 2'd3
    } pri_e;

    // Occupancy of the single service slot
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_arb_req_mask.sv
module dma_arb_req_mask #(
    parameter int unsigned NUM_CH = dma_arb_pkg::CH_COUNT_DEF
) (
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_trig,
    input  logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] pend
);

    // A request from either source counts only on an enabled channel
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign pend[c] = (hw_req[c] | sw_trig[c]) & ch_en[c];
        end
    endgenerate

endmodule

// File: rtl/dma_arb_level_stage.sv
module dma_arb_level_stage #(
    parameter int unsigned NUM_CH = dma_arb_pkg::CH_COUNT_DEF,
    parameter int unsigned LVL_W  = dma_arb_pkg::LVL_BITS_DEF
) (
    input  logic [NUM_CH-1:0]       pend,
    input  logic [NUM_CH*LVL_W-1:0] lvl_flat,
    output logic [NUM_CH-1:0]       cand,
    output logic                    any_pend
);

    localparam int unsigned NUM_LVL = 1 << LVL_W;

    logic [NUM_LVL-1:0][NUM_CH-1:0] at_lvl;
    logic [NUM_LVL-1:0]             lvl_hit;
    logic [LVL_W-1:0]               top_lvl;

    // Sort the pending channels into one vector per level
    generate
        for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
                assign at_lvl[l][c] = pend[c] &&
                    (lvl_flat[c*LVL_W +: LVL_W] == LVL_W'(l));
            end
            assign lvl_hit[l] = |at_lvl[l];
        end
    endgenerate

    // First stage: the highest level that has any pending channel
    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_hit[l]) begin
                top_lvl = LVL_W'(l);
            end
        end
    end

    assign cand     = at_lvl[top_lvl];
    assign any_pend = |lvl_hit;

endmodule

// File: rtl/dma_arb_low_pick.sv
module dma_arb_low_pick #(
    parameter int unsigned NUM_CH = dma_arb_pkg::CH_COUNT_DEF,
    parameter int unsigned IDX_W  = dma_arb_pkg::idx_bits(NUM_CH)
) (
    input  logic [NUM_CH-1:0] vec,
    output logic [NUM_CH-1:0] onehot,
    output logic [IDX_W-1:0]  idx
);

    // Second stage: isolate the lowest set bit of the candidate vector
    assign onehot = vec & (~vec + NUM_CH'(1));

    always_comb begin
        idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (vec[c]) begin
                idx = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/dma_arb_grant_reg.sv
module dma_arb_grant_reg #(
    parameter int unsigned NUM_CH = dma_arb_pkg::CH_COUNT_DEF,
    parameter int unsigned IDX_W  = dma_arb_pkg::idx_bits(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              item_done,
    input  logic              win_any,
    input  logic [NUM_CH-1:0] win_onehot,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [NUM_CH-1:0] grant,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_valid
);

    import dma_arb_pkg::*;

    slot_e             slot_q;
    logic [NUM_CH-1:0] grant_q;
    logic [IDX_W-1:0]  idx_q;
    logic              decide;

    // Decisions happen only when the slot is empty or the item ends
    assign decide = (slot_q == SLOT_FREE) || item_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= SLOT_FREE;
            grant_q <= '0;
            idx_q   <= '0;
        end else if (decide) begin
            slot_q  <= win_any ? SLOT_HELD : SLOT_FREE;
            grant_q <= win_any ? win_onehot : '0;
            idx_q   <= win_any ? win_idx : '0;
        end
    end

    assign grant       = grant_q;
    assign grant_idx   = idx_q;
    assign grant_valid = (slot_q == SLOT_HELD);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int unsigned NUM_CH = dma_arb_pkg::CH_COUNT_DEF,
    parameter int unsigned LVL_W  = dma_arb_pkg::LVL_BITS_DEF,
    localparam int unsigned IDX_W = dma_arb_pkg::idx_bits(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       hw_req,
    input  logic [NUM_CH-1:0]       sw_trig,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH*LVL_W-1:0] pri_lvl,
    input  logic                    item_done,
    output logic [NUM_CH-1:0]       grant,
    output logic [IDX_W-1:0]        grant_idx,
    output logic                    grant_valid
);

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] cand;
    logic              any_pend;
    logic [NUM_CH-1:0] win_onehot;
    logic [IDX_W-1:0]  win_idx;

    dma_arb_req_mask #(.NUM_CH(NUM_CH)) u_mask (
        .hw_req  (hw_req),
        .sw_trig (sw_trig),
        .ch_en   (ch_en),
        .pend    (pend)
    );

    dma_arb_level_stage #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_level (
        .pend     (pend),
        .lvl_flat (pri_lvl),
        .cand     (cand),
        .any_pend (any_pend)
    );

    dma_arb_low_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .vec    (cand),
        .onehot (win_onehot),
        .idx    (win_idx)
    );

    dma_arb_grant_reg #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .item_done   (item_done),
        .win_any     (any_pend),
        .win_onehot  (win_onehot),
        .win_idx     (win_idx),
        .grant       (grant),
        .grant_idx   (grant_idx),
        .grant_valid (grant_valid)
    );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int unsigned NUM_CH = dma_arb_pkg::CH_COUNT_DEF,
    parameter int unsigned LVL_W  = dma_arb_pkg::LVL_BITS_DEF,
    localparam int unsigned IDX_W = dma_arb_pkg::idx_bits(NUM_CH)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       hw_req,
    input logic [NUM_CH-1:0]       sw_trig,
    input logic [NUM_CH-1:0]       ch_en,
    input logic [NUM_CH*LVL_W-1:0] pri_lvl,
    input logic                    item_done,
    input logic [NUM_CH-1:0]       grant,
    input logic [IDX_W-1:0]        grant_idx,
    input logic                    grant_valid
);

    logic [NUM_CH-1:0] pend_c;
    logic              dec_c;
    logic              lvl_seen;

    assign pend_c   = (hw_req | sw_trig) & ch_en;
    assign dec_c    = !grant_valid || item_done;
    assign lvl_seen = |pri_lvl;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R5
    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        grant_valid == (grant != '0)); // R5
    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ($countones(grant >> grant_idx) == 1 && grant[0 +: 1] == (grant_idx == '0))); // R5
    AST_HOLD_MID_ITEM: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !item_done) |=> ($stable(grant) && $stable(grant_idx))); // R6
    AST_NEW_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
        dec_c |=> ((grant & ~$past(pend_c)) == '0)); // R2
    AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (dec_c && pend_c == '0) |=> !grant_valid); // R7
    AST_IDLE_PICKS: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && pend_c != '0) |=> grant_valid); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!grant_valid && grant == '0 && grant_idx == '0)); // R1

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
    .NUM_CH (NUM_CH),
    .LVL_W  (LVL_W)
) u_chk (.*);

// File: tb/dma_req_arbiter_tb_top.sv
module dma_req_arbiter_tb_top;

    import dma_arb_pkg::*;

    localparam int unsigned NCH  = 7;
    localparam int unsigned LW   = 2;
    localparam int unsigned IW   = 3;
    localparam int unsigned NRND = 4000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  hw_req = '0;
    logic [NCH-1:0]  sw_trig = '0;
    logic [NCH-1:0]  ch_en = '0;
    logic [NCH*LW-1:0] pri_lvl = '0;
    logic            item_done = 1'b0;
    logic [NCH-1:0]  grant;
    logic [IW-1:0]   grant_idx;
    logic            grant_valid;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    // expected state, computed by the reference chooser
    logic [NCH-1:0] e_grant = '0;
    logic [IW-1:0]  e_idx   = '0;
    logic           e_valid = 1'b0;
    string          e_tag   = "R1";

    always #5 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(NCH), .LVL_W(LW)) dut_i (
        .clk (clk), .rst (rst), .hw_req (hw_req), .sw_trig (sw_trig),
        .ch_en (ch_en), .pri_lvl (pri_lvl), .item_done (item_done),
        .grant (grant), .grant_idx (grant_idx), .grant_valid (grant_valid)
    );

    // Reference: scan channels, keep the first with a strictly greater level
    function automatic int pick(input logic [NCH-1:0] h, input logic [NCH-1:0] s,
                                input logic [NCH-1:0] en, input logic [NCH*LW-1:0] p);
        int best = -1;
        for (int c = 0; c < NCH; c++) begin
            if ((h[c] || s[c]) && en[c]) begin
                if (best < 0 || p[c*LW +: LW] > p[best*LW +: LW]) best = c;
            end
        end
        return best;
    endfunction

    function automatic logic [NCH*LW-1:0] lv(input pri_e l0, input pri_e l1, input pri_e l2,
            input pri_e l3, input pri_e l4, input pri_e l5, input pri_e l6);
        return {l6, l5, l4, l3, l2, l1, l0};
    endfunction

    task automatic check_now();
        total++;
        if (grant !== e_grant || grant_idx !== e_idx || grant_valid !== e_valid) begin
            bad++;
            $display("FAIL %s: got grant=%b idx=%0d valid=%0b exp grant=%b idx=%0d valid=%0b",
                     e_tag, grant, grant_idx, grant_valid, e_grant, e_idx, e_valid);
        end
        total++;
        if (!$onehot0(grant) || (grant_valid !== (grant != '0))) begin
            bad++;
            $display("FAIL R5: got grant=%b valid=%0b exp onehot0 and valid==|grant",
                     grant, grant_valid);
        end
    endtask

    // Check the previous result at negedge, then apply a new input set
    task automatic step(input logic [NCH-1:0] h, input logic [NCH-1:0] s,
                        input logic [NCH-1:0] en, input logic [NCH*LW-1:0] p,
                        input logic d, input string tag);
        int w;
        @(negedge clk);
        check_now();
        hw_req = h; sw_trig = s; ch_en = en; pri_lvl = p; item_done = d;
        if (!e_valid || d) begin
            w = pick(h, s, en, p);
            if (w < 0) begin
                e_grant = '0; e_idx = '0; e_valid = 1'b0;
            end else begin
                e_grant = NCH'(1) << w; e_idx = IW'(w); e_valid = 1'b1;
            end
        end
        e_tag = tag;
    endtask

    initial begin
        #2_000_000;
        if (!ended) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NCH*LW-1:0] pr;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now();                       // R1 during reset
        rst = 1'b0;
        step('0, '0, '1, '0, 1'b0, "R1");  // idle after release
        step('0, '0, '1, '0, 1'b0, "R10");
        // R10: done while idle and nothing pending
        step('0, '0, '1, '0, 1'b1, "R10");
        step('0, '0, '1, '0, 1'b0, "R10");
        // R2: ch3 requests at top level but is disabled, ch5 wins
        pr = lv(PRI_LOW, PRI_LOW, PRI_LOW, PRI_TOP, PRI_LOW, PRI_LOW, PRI_LOW);
        step(7'b010_1000, '0, 7'b111_0111, pr, 1'b0, "R2");
        step('0, '0, 7'b111_0111, pr, 1'b1, "R2");
        // R2: software trigger alone on ch2; R8 one-cycle latency from idle
        step('0, 7'b000_0100, '1, pr, 1'b0, "R8");
        step('0, '0, '1, pr, 1'b1, "R7");
        step('0, '0, '1, pr, 1'b0, "R7");
        // R4: ch1, ch4, ch6 tie at high, ch0 low
        pr = lv(PRI_LOW, PRI_HIGH, PRI_LOW, PRI_LOW, PRI_HIGH, PRI_LOW, PRI_HIGH);
        step(7'b101_0011, '0, '1, pr, 1'b0, "R4");
        step(7'b101_0001, '0, '1, pr, 1'b1, "R4");   // next: ch4
        step(7'b100_0001, '0, '1, pr, 1'b1, "R4");   // next: ch6
        step(7'b000_0001, '0, '1, pr, 1'b1, "R3");   // next: ch0
        step('0, '0, '1, pr, 1'b1, "R7");            // drains to idle
        // R3: ch0 low, ch6 top
        pr = lv(PRI_LOW, PRI_MED, PRI_MED, PRI_MED, PRI_MED, PRI_MED, PRI_TOP);
        step(7'b100_0001, '0, '1, pr, 1'b0, "R3");
        step(7'b000_0001, '0, '1, pr, 1'b1, "R3");
        // R6: ch0 held, ch5 becomes pending at top level, no done
        pr = lv(PRI_LOW, PRI_LOW, PRI_LOW, PRI_LOW, PRI_LOW, PRI_TOP, PRI_LOW);
        step(7'b010_0001, '0, '1, pr, 1'b0, "R6");
        step(7'b010_0001, '0, '1, pr, 1'b0, "R6");
        step(7'b010_0001, '0, '1, pr, 1'b0, "R6");
        // R9: levels swap mid-item, then done picks by the new levels
        pr = lv(PRI_TOP, PRI_LOW, PRI_LOW, PRI_LOW, PRI_LOW, PRI_LOW, PRI_LOW);
        step(7'b010_0001, '0, '1, pr, 1'b0, "R9");
        step(7'b010_0001, '0, '1, pr, 1'b1, "R9");   // ch0 again by new levels
        step(7'b010_0000, '0, '1, pr, 1'b1, "R9");
        step('0, '0, '1, pr, 1'b1, "R7");
        // random traffic
        for (int i = 0; i < NRND; i++) begin
            logic [NCH-1:0] h, s, en;
            logic d;
            string t;
            h  = NCH'($urandom);
            s  = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            en = NCH'($urandom) | NCH'($urandom);
            if ($urandom_range(0, 3) != 0) pr = (NCH*LW)'({$urandom});
            d  = ($urandom_range(0, 2) == 0);
            if (!e_valid) t = d ? "R10" : "R8";
            else          t = d ? "R7" : "R6";
            step(h, s, en, pr, d, t);
        end
        @(negedge clk);
        check_now();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule